// File: doc/BRIEF.md
# Range-Coalesced Second-Level Translation Buffer

This block is a second-level set-associative translation buffer that holds 4KB, 2MB and 1GB translations side by side in one array. Every lookup picks its set from the virtual page number bits just above the 4KB offset, whatever the page size turns out to be. A large page therefore has no single home set. Its translation is written into a way of every set, one copy per set. To offset the capacity those copies consume, one entry can describe a run of up to four consecutive large pages. The run is stored as a base translation plus a run length, not as a presence bitmap.

A lookup goes through two registered stages and a new request can enter every cycle. The first stage compares tags and checks the requested large-page number against the range held in each way of the indexed set. The second stage adds the page's distance from the run base, plus the 4KB-frame offset inside the large page, to the stored frame number. A fill port takes a base translation, a size code and a run length. An invalidate port names one 4KB virtual page. Every entry, in every set, whose coverage includes that page is removed as a whole.

Top module: `rc_l2_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low while no lookup is in flight, and any lookup misses.
- R2: A request presented on `req_valid` in cycle n gets its response with `rsp_valid` high in cycle n+2 and not earlier. Back-to-back requests are each answered in order, one per cycle.
- R3: A 4KB entry lives in the set chosen by `vpn[2:0]` and hits only on an exact virtual page number match. Its frame number is returned unchanged.
- R4: A large-page entry hits when two conditions hold. The requested large-page number (vpn shifted right by 9 for 2MB, by 18 for 1GB) must lie in the aligned group of four that holds the base. It must also fall within base to base plus `fill_len`. Fills keep the base position within the group plus `fill_len` at most 3, so runs never cross a group boundary.
- R5: On a large-page hit the returned 4KB frame number is the stored base frame, plus the run distance shifted left by 9 or 18, plus the low 9 or 18 bits of the requested vpn.
- R6: A large-page fill is written into every set, so lookups hit whatever the value of `vpn[2:0]`.
- R7: Size codes are 0 for 4KB, 1 for 2MB and 2 for 1GB, and 3 is never filled. A hit reports the entry's code on `rsp_size`. A miss drives `rsp_hit`, `rsp_size` and `rsp_pfn` to zero.
- R8: An invalidate of a 4KB virtual page removes the entire entry covering it, in every set. This includes all other large pages of the same run. Entries that do not cover the page stay.
- R9: A fill in the same cycle as an invalidate is dropped.
- R10: A fill takes the lowest-numbered invalid way of its set, otherwise the least recently used way. A lookup hit and a fill both make the touched way most recent.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill. The new translation is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number (4KB granularity) to translate |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | PFN_W | Physical 4KB frame number of the requested page |
| rsp_size | output | 2 | Size code of the hitting entry |
| fill_valid | input | 1 | Fill strobe |
| fill_vpn | input | VPN_W | Virtual page number of the run base |
| fill_pfn | input | PFN_W | Frame number of the run base |
| fill_size | input | 2 | Size code of the filled translation |
| fill_len | input | LEN_W | Extra large pages in the run (ignored for 4KB) |
| inv_valid | input | 1 | Invalidate strobe |
| inv_vpn | input | VPN_W | 4KB virtual page whose covering entries are dropped |

## Verification
The assertions rely on three properties of the fill input. Size code 3 never arrives. A large-page run never runs past its aligned group of four. The fill is never given a translation that an existing entry already covers. The bench meets all three by building runs from a random base position and a length drawn only from the room left in the group. It also keeps 4KB pages, 2MB runs and 1GB runs in separate top-bit regions of the virtual space, and it never refills a live translation. Directed cases cover run edges, eviction order and same-cycle collisions, and each is checked against a flat reference list of translations that knows nothing of sets or ways.

// File: rtl/rct_pkg.sv
package rct_pkg;

    // widest large-page offset, counted in 4KB frames
    localparam int unsigned OFF_W = 18;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_BAD = 2'd3
    } pg_size_e;

    function automatic int unsigned pg_shift(logic [1:0] sz);
        case (sz)
            2'd1:    return 9;
            2'd2:    return 18;
            default: return 0;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] pg_offmask(logic [1:0] sz);
        case (sz)
            2'd1:    return 18'h001FF;
            2'd2:    return 18'h3FFFF;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rct_match.sv
// Coverage test of one stored entry against one virtual page number.
module rct_match
    import rct_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int LEN_W = 2
) (
    input  logic             e_vld,
    input  logic [1:0]       e_sz,
    input  logic [LEN_W-1:0] e_len,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit,
    output logic [LEN_W-1:0] delta,
    output logic [OFF_W-1:0] off
);

    always_comb begin
        int unsigned sh;
        logic [VPN_W-1:0] r_sp;
        logic [VPN_W-1:0] b_sp;
        logic [LEN_W:0]   r_lo;
        logic [LEN_W:0]   b_lo;
        logic [LEN_W:0]   b_hi;
        sh    = pg_shift(e_sz);
        r_sp  = vpn >> sh;
        b_sp  = e_vpn >> sh;
        r_lo  = {1'b0, r_sp[LEN_W-1:0]};
        b_lo  = {1'b0, b_sp[LEN_W-1:0]};
        b_hi  = b_lo + {1'b0, e_len};
        hit   = 1'b0;
        delta = '0;
        off   = '0;
        if (e_vld) begin
            if (e_sz == PG_4K) begin
                hit = (vpn == e_vpn);
            end else if (e_sz != PG_BAD) begin
                // group tag equal and position inside [base, base+len]
                hit = ((r_sp >> LEN_W) == (b_sp >> LEN_W)) && (r_lo >= b_lo) && (r_lo <= b_hi);
                if (hit) begin
                    delta = r_sp[LEN_W-1:0] - b_sp[LEN_W-1:0];
                    off   = vpn[OFF_W-1:0] & pg_offmask(e_sz);
                end
            end
        end
    end

endmodule

// File: rtl/rct_lru.sv
// Per-set recency ages and victim choice.
module rct_lru #(
    parameter int WAYS  = 4,
    parameter int AGE_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0][AGE_W-1:0] age_q,
    input  logic [WAYS-1:0]            vld,
    input  logic                       hit_en,
    input  logic [AGE_W-1:0]           hit_way,
    input  logic                       fill_en,
    output logic [AGE_W-1:0]           victim,
    output logic [WAYS-1:0][AGE_W-1:0] age_d
);

    function automatic logic [WAYS-1:0][AGE_W-1:0] touch(
        input logic [WAYS-1:0][AGE_W-1:0] a,
        input logic [AGE_W-1:0]           way
    );
        logic [WAYS-1:0][AGE_W-1:0] r;
        r = a;
        for (int w = 0; w < WAYS; w++) begin
            if (a[w] < a[way]) r[w] = a[w] + 1'b1;
        end
        r[way] = '0;
        return r;
    endfunction

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[w] && !found) begin
                victim = AGE_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[w] == AGE_W'(WAYS - 1)) victim = AGE_W'(w);
            end
        end
        age_d = age_q;
        if (hit_en)  age_d = touch(age_d, hit_way);
        if (fill_en) age_d = touch(age_d, victim);
    end

    logic [WAYS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++) seen[age_q[w]] = 1'b1;
    end

    // ages must stay a permutation, else the victim search could find nothing
    assert_age_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == WAYS);

endmodule

// File: rtl/rct_addr.sv
// Second lookup stage: frame = base + (run distance << shift) + offset.
module rct_addr
    import rct_pkg::*;
#(
    parameter int PFN_W = 36,
    parameter int LEN_W = 2
) (
    input  logic [PFN_W-1:0] base,
    input  logic [LEN_W-1:0] delta,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       sz,
    output logic [PFN_W-1:0] pfn
);

    always_comb begin
        pfn = base + (PFN_W'(delta) << pg_shift(sz)) + PFN_W'(off);
    end

endmodule

// File: rtl/rc_l2_tlb.sv
module rc_l2_tlb
    import rct_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int PFN_W = 36,
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic [1:0]       rsp_size,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_size,
    input  logic [LEN_W-1:0] fill_len,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn
);

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int RUN_MAX = (1 << LEN_W) - 1;

    typedef struct packed {
        logic             vld;
        logic [1:0]       sz;
        logic [LEN_W-1:0] len;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } ent_t;

    typedef struct packed {
        ent_t [SETS-1:0][WAYS-1:0]             ent;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age;
        logic                                  s1_vld;
        logic                                  s1_hit;
        logic [1:0]                            s1_sz;
        logic [PFN_W-1:0]                      s1_pfn;
        logic [LEN_W-1:0]                      s1_delta;
        logic [OFF_W-1:0]                      s1_off;
        logic                                  rsp_vld;
        logic                                  rsp_hit;
        logic [1:0]                            rsp_sz;
        logic [PFN_W-1:0]                      rsp_pfn;
    } st_t;

    st_t q, d;

    // ---------------- lookup stage 1: compare ----------------
    logic [IDX_W-1:0]            lk_set;
    logic [WAYS-1:0]             lk_hit;
    logic [WAYS-1:0][LEN_W-1:0]  lk_delta;
    logic [WAYS-1:0][OFF_W-1:0]  lk_off;
    logic                        lk_any;
    logic [WAY_W-1:0]            lk_way;

    assign lk_set = req_vpn[IDX_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_lk
        rct_match #(.VPN_W(VPN_W), .LEN_W(LEN_W)) i_lk_match (
            .e_vld (q.ent[lk_set][w].vld),
            .e_sz  (q.ent[lk_set][w].sz),
            .e_len (q.ent[lk_set][w].len),
            .e_vpn (q.ent[lk_set][w].vpn),
            .vpn   (req_vpn),
            .hit   (lk_hit[w]),
            .delta (lk_delta[w]),
            .off   (lk_off[w])
        );
    end

    always_comb begin
        lk_any = 1'b0;
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_hit[w]) begin
                lk_any = 1'b1;
                lk_way = WAY_W'(w);
            end
        end
    end

    // ---------------- lookup stage 2: address add ----------------
    logic [PFN_W-1:0] add_pfn;

    rct_addr #(.PFN_W(PFN_W), .LEN_W(LEN_W)) i_addr (
        .base  (q.s1_pfn),
        .delta (q.s1_delta),
        .off   (q.s1_off),
        .sz    (q.s1_sz),
        .pfn   (add_pfn)
    );

    // ---------------- invalidate coverage over the whole array ----------------
    logic [SETS-1:0][WAYS-1:0] inv_hit;

    for (genvar s = 0; s < SETS; s++) begin : g_inv_s
        for (genvar w = 0; w < WAYS; w++) begin : g_inv_w
            logic [LEN_W-1:0] unused_delta;
            logic [OFF_W-1:0] unused_off;
            rct_match #(.VPN_W(VPN_W), .LEN_W(LEN_W)) i_inv_match (
                .e_vld (q.ent[s][w].vld),
                .e_sz  (q.ent[s][w].sz),
                .e_len (q.ent[s][w].len),
                .e_vpn (q.ent[s][w].vpn),
                .vpn   (inv_vpn),
                .hit   (inv_hit[s][w]),
                .delta (unused_delta),
                .off   (unused_off)
            );
        end
    end

    // ---------------- fill and replacement ----------------
    logic                                 fill_super;
    logic [SETS-1:0]                      fill_set_en;
    logic [SETS-1:0][WAY_W-1:0]           victim;
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_nxt;
    logic [SETS-1:0][WAYS-1:0]            set_vld;
    ent_t                                 fill_ent;

    assign fill_super = (fill_size != PG_4K);

    always_comb begin
        fill_ent.vld = 1'b1;
        fill_ent.sz  = fill_size;
        fill_ent.len = fill_super ? fill_len : '0;
        fill_ent.vpn = fill_vpn & ~VPN_W'(pg_offmask(fill_size));
        fill_ent.pfn = fill_pfn & ~PFN_W'(pg_offmask(fill_size));
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_vld
            assign set_vld[s][w] = q.ent[s][w].vld;
        end

        // large pages are mirrored into every set
        assign fill_set_en[s] = fill_valid && !inv_valid &&
                                (fill_super || (fill_vpn[IDX_W-1:0] == IDX_W'(s)));

        rct_lru #(.WAYS(WAYS), .AGE_W(WAY_W)) i_lru (
            .clk     (clk),
            .rst_n   (rst_n),
            .age_q   (q.age[s]),
            .vld     (set_vld[s]),
            .hit_en  (req_valid && lk_any && (lk_set == IDX_W'(s))),
            .hit_way (lk_way),
            .fill_en (fill_set_en[s]),
            .victim  (victim[s]),
            .age_d   (age_nxt[s])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        d = q;

        d.rsp_vld = q.s1_vld;
        d.rsp_hit = q.s1_hit;
        d.rsp_sz  = q.s1_hit ? q.s1_sz : 2'd0;
        d.rsp_pfn = q.s1_hit ? add_pfn : '0;

        d.s1_vld   = req_valid;
        d.s1_hit   = req_valid && lk_any;
        d.s1_sz    = '0;
        d.s1_pfn   = '0;
        d.s1_delta = '0;
        d.s1_off   = '0;
        if (req_valid && lk_any) begin
            d.s1_sz    = q.ent[lk_set][lk_way].sz;
            d.s1_pfn   = q.ent[lk_set][lk_way].pfn;
            d.s1_delta = lk_delta[lk_way];
            d.s1_off   = lk_off[lk_way];
        end

        if (inv_valid) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (inv_hit[s][w]) d.ent[s][w].vld = 1'b0;
                end
            end
        end

        for (int s = 0; s < SETS; s++) begin
            if (fill_set_en[s]) d.ent[s][victim[s]] = fill_ent;
        end

        d.age = age_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    q.age[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_vld;
    assign rsp_hit   = q.rsp_hit;
    assign rsp_pfn   = q.rsp_pfn;
    assign rsp_size  = q.rsp_sz;

    // ---------------- checks ----------------
    logic             chk_inv_q;
    logic             chk_fill_q;
    logic [VPN_W-1:0] chk_inv_vpn_q;
    logic [VPN_W-1:0] chk_fill_vpn_q;
    logic [SETS-1:0][WAYS-1:0] chk_inv_cov;
    logic [SETS-1:0][WAYS-1:0] chk_fill_cov;
    logic [VPN_W-1:0] fill_grp_sp;
    logic [LEN_W:0]   fill_run_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_inv_q      <= 1'b0;
            chk_fill_q     <= 1'b0;
            chk_inv_vpn_q  <= '0;
            chk_fill_vpn_q <= '0;
        end else begin
            chk_inv_q      <= inv_valid;
            chk_fill_q     <= fill_valid && !inv_valid && fill_super;
            chk_inv_vpn_q  <= inv_vpn;
            chk_fill_vpn_q <= fill_vpn;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk_s
        for (genvar w = 0; w < WAYS; w++) begin : g_chk_w
            logic [LEN_W-1:0] ci_delta, cf_delta;
            logic [OFF_W-1:0] ci_off, cf_off;
            rct_match #(.VPN_W(VPN_W), .LEN_W(LEN_W)) i_chk_inv (
                .e_vld (q.ent[s][w].vld), .e_sz (q.ent[s][w].sz),
                .e_len (q.ent[s][w].len), .e_vpn (q.ent[s][w].vpn),
                .vpn   (chk_inv_vpn_q), .hit (chk_inv_cov[s][w]),
                .delta (ci_delta), .off (ci_off)
            );
            rct_match #(.VPN_W(VPN_W), .LEN_W(LEN_W)) i_chk_fill (
                .e_vld (q.ent[s][w].vld), .e_sz (q.ent[s][w].sz),
                .e_len (q.ent[s][w].len), .e_vpn (q.ent[s][w].vpn),
                .vpn   (chk_fill_vpn_q), .hit (chk_fill_cov[s][w]),
                .delta (cf_delta), .off (cf_off)
            );
        end
    end

    logic [SETS-1:0] chk_set_has_fill;
    always_comb begin
        for (int s = 0; s < SETS; s++) chk_set_has_fill[s] = |chk_fill_cov[s];
    end

    assign fill_grp_sp  = fill_vpn >> pg_shift(fill_size);
    assign fill_run_end = {1'b0, fill_grp_sp[LEN_W-1:0]} + {1'b0, fill_len};

    // input assumption: legal size code and a run that stays inside its group
    assert_fill_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_super) |-> (fill_size != PG_BAD) && (fill_run_end <= RUN_MAX));

    assert_lat_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    assert_lat_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !rsp_valid);

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0) && (rsp_size == 2'd0));

    assert_inv_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_inv_q |-> (chk_inv_cov == '0));

    assert_mirror_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fill_q |-> (&chk_set_has_fill));

endmodule

// File: tb/test_rc_l2_tlb.sv
module test_rc_l2_tlb;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 36;
    localparam int PW = 36;
    localparam int LW = 2;
    localparam int NM = 16;

    logic          clk;
    logic          rst_n;
    logic          req_valid;
    logic [VW-1:0] req_vpn;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [PW-1:0] rsp_pfn;
    logic [1:0]    rsp_size;
    logic          fill_valid;
    logic [VW-1:0] fill_vpn;
    logic [PW-1:0] fill_pfn;
    logic [1:0]    fill_size;
    logic [LW-1:0] fill_len;
    logic          inv_valid;
    logic [VW-1:0] inv_vpn;

    rc_l2_tlb i_rc_l2_tlb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_size(rsp_size),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .fill_len(fill_len),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // flat reference list of live translations
    logic          m_vld [NM];
    logic [VW-1:0] m_vpn [NM];
    logic [PW-1:0] m_pfn [NM];
    logic [1:0]    m_sz  [NM];
    logic [LW-1:0] m_len [NM];
    int            m_cnt = 0;

    function automatic int sh_of(input logic [1:0] sz);
        return (sz == 2'd1) ? 9 : (sz == 2'd2) ? 18 : 0;
    endfunction

    // {hit, size, pfn}; all zero on a miss (R7)
    function automatic logic [38:0] ref_xlate(input logic [VW-1:0] vpn);
        for (int i = 0; i < m_cnt; i++) begin
            int sh;
            logic [VW-1:0] sp, bsp;
            sh  = sh_of(m_sz[i]);
            sp  = vpn >> sh;
            bsp = m_vpn[i] >> sh;
            if (m_vld[i]) begin
                if (m_sz[i] == 2'd0) begin
                    if (vpn == m_vpn[i]) return {1'b1, 2'd0, m_pfn[i]};
                end else if (sp >= bsp && sp <= bsp + VW'(m_len[i])) begin
                    return {1'b1, m_sz[i],
                            m_pfn[i] + ((sp - bsp) << sh) + (vpn & ((36'd1 << sh) - 36'd1))};
                end
            end
        end
        return '0;
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
    endtask

    task automatic add_model(input logic [VW-1:0] v, input logic [PW-1:0] p,
                             input logic [1:0] sz, input logic [LW-1:0] ln);
        m_vld[m_cnt] = 1'b1; m_vpn[m_cnt] = v; m_pfn[m_cnt] = p;
        m_sz[m_cnt] = sz; m_len[m_cnt] = (sz == 2'd0) ? '0 : ln;
        m_cnt++;
    endtask

    task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                        input logic [1:0] sz, input logic [LW-1:0] ln);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_size = sz; fill_len = ln;
        @(negedge clk);
        fill_valid = 1'b0;
        add_model(v, p, sz, ln);
    endtask

    task automatic invalidate(input logic [VW-1:0] v);
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = v;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic lookup(input logic [VW-1:0] v, input string rq);
        logic [38:0] e;
        e = ref_xlate(v);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = v;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rq, {rsp_valid, rsp_hit, rsp_size, rsp_pfn}, {1'b1, e});
    endtask

    initial begin
        logic [VW-1:0] a_vpn [5];
        logic [VW-1:0] sp2, sp1, v;
        logic [PW-1:0] p;
        logic [VW-1:0] r2_vpn, r1_vpn;
        logic [1:0]    r2_len, r1_len;
        void'($urandom(32'd20240611));
        req_vpn = '0; fill_vpn = '0; fill_pfn = '0; fill_size = '0; fill_len = '0; inv_vpn = '0;
        do_reset();

        // R1: idle output and empty array after reset
        @(negedge clk);
        check("R1 rsp_valid idle", rsp_valid, 1'b0);
        lookup(36'h1_2345_6789, "R1 miss after reset");

        // R10: invalid ways first, then least recent
        for (int k = 0; k < 5; k++) a_vpn[k] = 36'h2_0000_0000 | (36'(k) << 3) | 36'd5;
        for (int k = 0; k < 4; k++) fill(a_vpn[k], 36'h0_0100_0000 + 36'(k), 2'd0, 2'd0);
        lookup(a_vpn[0], "R10 touch way of first page");
        fill(a_vpn[4], 36'h0_0100_0004, 2'd0, 2'd0);
        m_vld[1] = 1'b0; // second page is now least recent and evicted
        for (int k = 0; k < 5; k++) lookup(a_vpn[k], "R10 eviction order");

        do_reset();

        // R3: small pages
        fill(36'h3_0000_0012, 36'h0_0005_5555, 2'd0, 2'd0);
        lookup(36'h3_0000_0012, "R3 small hit");
        lookup(36'h3_0000_001A, "R3 same set other tag miss");

        // R11: same-cycle fill and lookup
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 36'h3_0000_0023; fill_pfn = 36'h0_0007_7777;
        fill_size = 2'd0; fill_len = '0;
        req_valid = 1'b1; req_vpn = 36'h3_0000_0023;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check("R11 lookup sees old contents", {rsp_valid, rsp_hit}, 2'b10);
        add_model(36'h3_0000_0023, 36'h0_0007_7777, 2'd0, 2'd0);
        lookup(36'h3_0000_0023, "R11 visible next cycle");

        // R4 R5 R6: 2MB run with base at position 1, length field 2
        sp2 = 36'h12341;
        fill(sp2 << 9, 36'h0_00AB_C000, 2'd1, 2'd2);
        lookup(36'h12340 << 9, "R4 below run miss");
        lookup(36'h12341 << 9, "R4 run base hit");
        lookup((36'h12342 << 9) | 36'h0C3, "R4 run middle hit");
        lookup((36'h12343 << 9) | 36'h1A5, "R4 run end hit");
        lookup(36'h12344 << 9, "R4 next group miss");
        // R5: hard value = base + (2<<9) + 0x1A5
        @(negedge clk);
        req_valid = 1'b1; req_vpn = (36'h12343 << 9) | 36'h1A5;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R5 frame sum", rsp_pfn, 36'h0_00AB_C5A5);
        for (int s = 0; s < 8; s++) lookup((36'h12342 << 9) | 36'h0F0 | 36'(s), "R6 mirror in every set");

        // R7: 1GB run at position 2 with length field 1
        sp1 = 36'h00A06;
        fill(sp1 << 18, 36'h0_000C_0000, 2'd2, 2'd1);
        lookup(36'h00A05 << 18, "R7 1GB below miss");
        lookup((36'h00A06 << 18) | 36'h2_1234, "R7 1GB hit size code");
        lookup((36'h00A07 << 18) | 36'h3_FFFF, "R7 1GB run end");
        lookup(36'h00A08 << 18, "R7 1GB after miss");

        // R2: nothing one cycle after a request, then streaming
        @(negedge clk);
        req_valid = 1'b1; req_vpn = 36'h3_0000_0012;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 no response after one cycle", rsp_valid, 1'b0);
        @(negedge clk);
        check("R2 response after two cycles", {rsp_valid, rsp_hit}, 2'b11);
        begin
            logic [VW-1:0] pv [3];
            pv[0] = 36'h3_0000_0012; pv[1] = 36'h12342 << 9; pv[2] = 36'h12340 << 9;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (i >= 2) check("R2 back-to-back", {rsp_valid, rsp_hit, rsp_size, rsp_pfn},
                                  {1'b1, ref_xlate(pv[i - 2])});
                req_valid = (i < 3);
                if (i < 3) req_vpn = pv[i];
            end
            @(negedge clk);
            req_valid = 1'b0;
        end

        // R8: invalidate one page of the 2MB run drops the whole run
        invalidate((36'h12342 << 9) | 36'h077);
        m_vld[2] = 1'b0;
        lookup(36'h12341 << 9, "R8 run base gone");
        lookup((36'h12343 << 9) | 36'h005, "R8 run end gone");
        lookup((36'h00A06 << 18) | 36'h0_0044, "R8 other run kept");
        lookup(36'h3_0000_0012, "R8 small page kept");

        // R9: invalidate wins over a same-cycle fill
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = 36'h0_0000_0777;
        fill_valid = 1'b1; fill_vpn = 36'h3_0000_0034; fill_pfn = 36'h0_0009_9999;
        fill_size = 2'd0; fill_len = '0;
        @(negedge clk);
        inv_valid = 1'b0; fill_valid = 1'b0;
        lookup(36'h3_0000_0034, "R9 fill dropped");

        // random phase
        do_reset();
        r2_len = 2'($urandom % 4);
        r2_len = 2'($urandom % (4 - r2_len));
        r2_vpn = {2'b01, 23'($urandom), 2'($urandom % (4 - r2_len)), 9'd0};
        r1_len = 2'($urandom % 4);
        r1_vpn = {2'b10, 14'($urandom), 2'($urandom % (4 - r1_len)), 18'd0};
        fill(r2_vpn, {9'd0, 27'($urandom)} << 9, 2'd1, r2_len);
        fill(r1_vpn, {18'd0, 18'($urandom)} << 18, 2'd2, r1_len);
        for (int s = 0; s < 8; s++)
            fill({2'b11, 31'($urandom), 3'(s)}, 36'($urandom), 2'd0, 2'd0);
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom % 10;
            if (k < 8) begin
                v = m_vpn[2 + k] ^ (($urandom % 2) ? 36'h8 : 36'h0);
                lookup(v, "R3 random small");
            end else if (k == 8) begin
                p = ((r2_vpn >> 9) & ~36'h3) | 36'($urandom % 4);
                if ($urandom % 8 == 0) p = p + 36'd4;
                lookup((p << 9) | 36'($urandom % 512), "R4 random 2MB run");
            end else begin
                p = ((r1_vpn >> 18) & ~36'h3) | 36'($urandom % 4);
                if ($urandom % 8 == 0) p = p - 36'd4;
                lookup((p << 18) | 36'($urandom % 262144), "R5 random 1GB run");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule